// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked internal bus and an asynchronous byte-wide static RAM that has 11 address lines, an active-low chip select, an active-low write enable, an active-low output enable and one shared 8-bit data bus. A client raises a single-word read or write request. The sequencer latches the request and steps the memory pins through a fixed order. Because it moves one pin per clock, the part's own timing rules are met by construction and no clock reaches the memory.

A write is committed by the rising edge of chip select, not by a clock edge. The write data is therefore still driven, and write enable is still low, at the moment chip select returns high. On a read the output enable is pulled low while write enable stays high. The read data is sampled a programmable number of clocks after the address was first applied, because access time is counted from the address. The shared data bus is driven by the sequencer only during the data phase of a write. The bench models the bidirectional bus as three separate signals: data out, data enable and data in. One extra idle step is inserted when a write follows a read, so that the two drivers never overlap.

Top module: `sram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the operation ends. A `req_valid` pulse while `req_ready` is 0 is dropped: it causes no memory write and no `done`.
- R3: A write applies the address with `mem_cs_n` high for one cycle. Next, `mem_cs_n` goes low. One cycle later `mem_we_n` goes low, with `mem_oe_n` high. On the following cycle the write data is driven (`mem_dq_oe`=1) and is held for ACCESS_CYCLES cycles. Then `mem_cs_n` rises while `mem_we_n` is still 0 and the data is still driven, and that rising edge stores the byte.
- R4: A read applies the address, then pulls `mem_cs_n` low one cycle later, then pulls `mem_oe_n` low one cycle after that, with `mem_we_n` high throughout. `mem_dq_i` is captured on the clock edge ACCESS_CYCLES edges after the address was applied.
- R5: Counting the accepting edge as edge 0, `done` rises after edge ACCESS_CYCLES for a read and after edge ACCESS_CYCLES+3 for a write.
- R6: A write accepted when the last completed operation was a read spends one extra cycle with the data drivers off before the address is applied. Its `done` therefore comes one edge later than the R5 figure.
- R7: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0.
- R8: `done` is high for exactly one cycle per operation. At a read's `done`, `rdata` holds the captured byte, and it keeps that value until another read captures.
- R9: `mem_addr` does not change while `mem_cs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data bus as seen from the memory side |

## Verification
A wrong state or a miscounted wait shows up directly at the ports:
- **Timing errors.** The `done` pulse lands on the wrong edge, which shows within one operation, or read data is sampled while output enable is still high. The memory model then returns a filler byte, and the first readback after the error catches it.
- **Write-commit errors.** If chip select rises without data or write enable held, the byte is never stored. That shows at the next read of the same address.
- **Drive and address errors.** A driver overlap or an address change under an active chip select is visible in the same cycle. Bus monitors count these and assertions flag them.
- **Dropped-request errors.** A request that is taken while the sequencer is busy shows up as an extra commit, or as a changed byte at an address that is checked later.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TURN,
    ST_ADDR,
    ST_W_CS,
    ST_W_WE,
    ST_W_DATA,
    ST_W_END,
    ST_R_CS,
    ST_R_OE,
    ST_R_END
  } seq_state_t;

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output logic       accept,
  output logic       capture,
  output seq_state_t state_d
);

  localparam int CNT_W = $clog2(ACCESS_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACCESS_CYCLES - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             write_q;
  logic             last_rd_q;
  logic             cnt_clear;
  logic             wait_over;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign wait_over = (cnt_q == LAST_CNT);
  assign capture   = (state_q == ST_R_OE) && wait_over;
  assign cnt_clear = (state_q != state_d) &&
                     ((state_d == ST_ADDR) || (state_d == ST_W_DATA));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = (req_write && last_rd_q) ? ST_TURN : ST_ADDR;
        end
      end
      ST_TURN:   state_d = ST_ADDR;
      ST_ADDR:   state_d = write_q ? ST_W_CS : ST_R_CS;
      ST_W_CS:   state_d = ST_W_WE;
      ST_W_WE:   state_d = ST_W_DATA;
      ST_W_DATA: if (wait_over) state_d = ST_W_END;
      ST_W_END:  state_d = ST_IDLE;
      ST_R_CS:   state_d = ST_R_OE;
      ST_R_OE:   if (wait_over) state_d = ST_R_END;
      ST_R_END:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      write_q   <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_clear) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
      if (accept) write_q <= req_write;
      if (state_q == ST_R_END) last_rd_q <= 1'b1;
      if (state_q == ST_W_END) last_rd_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state_d,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic cs_on, we_on, oe_on, drv_on, end_on;

  always_comb begin
    cs_on  = (state_d == ST_W_CS)   || (state_d == ST_W_WE) ||
             (state_d == ST_W_DATA) || (state_d == ST_R_CS) ||
             (state_d == ST_R_OE);
    we_on  = (state_d == ST_W_WE)   || (state_d == ST_W_DATA) ||
             (state_d == ST_W_END);
    oe_on  = (state_d == ST_R_OE);
    drv_on = (state_d == ST_W_DATA) || (state_d == ST_W_END);
    end_on = (state_d == ST_W_END)  || (state_d == ST_R_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      mem_cs_n  <= ~cs_on;
      mem_we_n  <= ~we_on;
      mem_oe_n  <= ~oe_on;
      mem_dq_oe <= drv_on;
      done      <= end_on;
      if (capture) rdata <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int ACCESS_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  seq_state_t state_d;
  logic       accept;
  logic       capture;

  sram_seq_ctrl #(
    .ACCESS_CYCLES(ACCESS_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .capture  (capture),
    .state_d  (state_d)
  );

  sram_seq_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) pins_i (
    .clk      (clk),
    .rst      (rst),
    .state_d  (state_d),
    .accept   (accept),
    .capture  (capture),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_dq_i (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe),
    .done     (done),
    .rdata    (rdata)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  AST_READY_DROP_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(req_ready) |-> $past(req_valid)); // R2

  AST_WE_FALL_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> (!mem_cs_n && mem_oe_n)); // R3

  AST_COMMIT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_cs_n) && !mem_we_n) |-> mem_dq_oe); // R3

  AST_OE_NOT_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n); // R4

  AST_NO_DRIVE_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> $stable(mem_addr)); // R9

endmodule

bind sram_seq sram_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_seq_tb.sv
`timescale 1ns/1ps
module sram_seq_tb_top;

  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int ACC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  int errors = 0;
  int checks = 0;
  int commits = 0;
  int clashes = 0;
  int addr_moves = 0;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] prev_addr;

  always #4 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYCLES(ACC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory: drives data only while selected and output-enabled
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : 8'hEE;

  always @(posedge mem_cs_n) begin
    if (!rst && mem_we_n === 1'b0) begin
      commits = commits + 1;
      if (mem_dq_oe === 1'b1) mem[mem_addr] = mem_dq_o;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_dq_oe === 1'b1 && mem_oe_n === 1'b0) clashes++;
      if (mem_cs_n === 1'b0 && mem_addr !== prev_addr) addr_moves++;
    end
    prev_addr = mem_addr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output int lat, output logic [DW-1:0] rd);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      req_valid = 1'b0;
      if (done) break;
    end
    lat = n;
    rd  = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(mem_cs_n == 1'b1, "R1 cs_n", int'(mem_cs_n), 1);
    chk(mem_we_n == 1'b1, "R1 we_n", int'(mem_we_n), 1);
    chk(mem_oe_n == 1'b1, "R1 oe_n", int'(mem_oe_n), 1);
    chk(mem_dq_oe == 1'b0, "R1 dq_oe", int'(mem_dq_oe), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_write_read();
    int lat; logic [DW-1:0] rd;
    int c0 = commits;
    do_op(1'b1, 11'h000, 8'h5A, lat, rd);
    chk(lat == ACC + 4, "R5 write latency", lat, ACC + 4);
    do_op(1'b1, 11'h7FF, 8'hA5, lat, rd);
    do_op(1'b1, 11'h123, 8'h3C, lat, rd);
    chk(commits == c0 + 3, "R3 commit count", commits, c0 + 3);
    chk(mem[11'h7FF] == 8'hA5, "R3 stored top addr", int'(mem[11'h7FF]), 'hA5);
    do_op(1'b0, 11'h000, 8'h00, lat, rd);
    chk(lat == ACC + 1, "R5 read latency", lat, ACC + 1);
    chk(rd == 8'h5A, "R4 read addr 0", int'(rd), 'h5A);
    do_op(1'b0, 11'h7FF, 8'h00, lat, rd);
    chk(rd == 8'hA5, "R4 read top addr", int'(rd), 'hA5);
    do_op(1'b0, 11'h123, 8'h00, lat, rd);
    chk(rd == 8'h3C, "R4 read mid addr", int'(rd), 'h3C);
  endtask

  task automatic t_hold_and_turn();
    int lat; logic [DW-1:0] rd;
    repeat (5) @(negedge clk);
    chk(rdata == 8'h3C, "R8 rdata held", int'(rdata), 'h3C);
    do_op(1'b1, 11'h055, 8'hC3, lat, rd);
    chk(lat == ACC + 5, "R6 write after read latency", lat, ACC + 5);
    chk(rdata == 8'h3C, "R8 rdata kept across write", int'(rdata), 'h3C);
    do_op(1'b1, 11'h056, 8'h96, lat, rd);
    chk(lat == ACC + 4, "R6 write after write no gap", lat, ACC + 4);
    do_op(1'b0, 11'h055, 8'h00, lat, rd);
    chk(rd == 8'hC3, "R6 data after turnaround", int'(rd), 'hC3);
  endtask

  task automatic t_ignore();
    int lat; logic [DW-1:0] rd; int c0;
    do_op(1'b1, 11'h020, 8'h44, lat, rd);
    c0 = commits;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h010; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b0, "R2 busy ready low", int'(req_ready), 0);
    req_valid = 1'b1; req_addr = 11'h020; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(commits == c0 + 1, "R2 single commit", commits, c0 + 1);
    do_op(1'b0, 11'h020, 8'h00, lat, rd);
    chk(rd == 8'h44, "R2 dropped request no effect", int'(rd), 'h44);
    do_op(1'b0, 11'h010, 8'h00, lat, rd);
    chk(rd == 8'h11, "R2 accepted write stored", int'(rd), 'h11);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_hold_and_turn();
    t_ignore();
    chk(clashes == 0, "R7 drive clash cycles", clashes, 0);
    chk(addr_moves == 0, "R9 address moves under select", addr_moves, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule